// File: doc/BRIEF.md
# Reloadable System Tick Down-Counter

This block is a periodic tick source for a processor subsystem. A 24-bit counter is loaded from a programmable reload value and counts down to zero. The counting tick that finds it at zero is a wrap: the counter takes the reload value again, a sticky wrap flag is set, and, if interrupt requests are allowed, a single-cycle request pulse goes out. Each counting tick is either every clock cycle or a cycle in which the slow reference-tick enable input is high. A control bit picks which.

Software reaches the block over a simple 32-bit register port with four word registers, selected by a 2-bit word index. Several accesses have side effects. Reading the control word clears the wrap flag. Any write to the current-value word restarts the count from the reload value. Toggling the tick source also restarts the count. A reload value of zero makes the timer switch itself off at its next wrap, which gives a one-shot mode.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the control word, reload word and current word all read 0, and `tick_irq` is low.
- R2: The control word (index 0) holds run at bit 0, request-enable at bit 1, tick-source at bit 2 and the wrap flag at bit 16. Only bits 2..0 take written data. Bit 16 and all other bits ignore writes, and the bits other than 0, 1, 2 and 16 read 0.
- R3: The reload word (index 1) and the current word (index 2) are 24 bits wide and read 0 in bits 31..24. The calibration word (index 3) always reads 10000, and writes to it have no effect.
- R4: A control write that changes run from 0 to 1 loads the counter from the reload word. From then on, wraps fall exactly reload+1 counting ticks apart.
- R5: With tick-source at 1 the counter moves on every clock. With tick-source at 0 it moves only in cycles where `ref_tick_en` is high.
- R6: A wrap sets the wrap flag. A control read returns the flag as it stood and then clears it. A wrap in the same cycle as a clear leaves the flag set.
- R7: When request-enable is 1, `tick_irq` is high for exactly the one cycle after the wrap edge. When request-enable is 0 it stays low.
- R8: Any write to the current word, whatever the data, loads the counter from the reload word and clears the wrap flag.
- R9: If the reload word is 0 at a wrap, run clears itself at that edge and counting stops.
- R10: The current word reads 0 while run is 0.
- R11: A control write that changes tick-source reloads the counter. A reload caused by the bus takes priority over counting in the same cycle, and no wrap occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick_en | input | 1 | Slow reference tick, one cycle wide per tick |
| bus_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word index: 0 control, 1 reload, 2 current, 3 calibration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the index and state |
| tick_irq | output | 1 | One-cycle wrap interrupt request |

## Verification
Read data is combinational and shows the state from before the strobed edge, so the bench samples it 1 ns after the negative edge, while the strobe is applied. A write, and the read-side clear of the wrap flag, are visible from the next negative edge on. After an enabling write, the counter holds the reload value R. It reaches zero R counting ticks later and wraps on tick R+1. `tick_irq` rises one register later, at the edge of that wrap, so the bench counts negative edges from the write and expects the pulse at index R+1 and again at 2R+2. The gated-tick, source-change and one-shot checks use the same counting of edges, with the reference tick held high for a known number of posedges.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LOAD = 2'd1,
    REG_CUR  = 2'd2,
    REG_CAL  = 2'd3
  } stk_reg_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;

  typedef struct packed {
    logic src;
    logic ie;
    logic run;
  } stk_mode_t;

endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/stk_bus_decode.sv
module stk_bus_decode
  import stk_pkg::*;
(
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  output logic       wr_ctrl,
  output logic       wr_load,
  output logic       wr_cur,
  output logic       rd_ctrl
);
  logic [3:0] sel;

  for (genvar i = 0; i < 4; i++) begin : g_sel
    assign sel[i] = (bus_addr == 2'(i));
  end

  always_comb begin
    wr_ctrl = bus_wr & sel[REG_CTRL];
    wr_load = bus_wr & sel[REG_LOAD];
    wr_cur  = bus_wr & sel[REG_CUR];
    rd_ctrl = bus_rd & sel[REG_CTRL];
  end
endmodule

// File: rtl/stk_ctrl_regs.sv
module stk_ctrl_regs
  import stk_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_load,
  input  logic             wr_cur,
  input  logic             rd_ctrl,
  input  logic [2:0]       wmode,
  input  logic [CNT_W-1:0] wreload,
  input  logic             wrap,
  output stk_mode_t        mode,
  output logic             flag,
  output logic [CNT_W-1:0] reload,
  output logic             load_req,
  output logic             tick_irq
);
  stk_mode_t        mode_q, mode_d;
  logic             mode_ce;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] reload_q;
  logic             irq_q;
  logic             self_stop;

  always_comb begin
    self_stop = wrap & (reload_q == '0);
    mode_ce   = wr_ctrl | self_stop;
    mode_d    = mode_q;
    if (wr_ctrl) begin
      mode_d.run = wmode[CTRL_RUN_BIT];
      mode_d.ie  = wmode[CTRL_IE_BIT];
      mode_d.src = wmode[CTRL_SRC_BIT];
    end else if (self_stop) begin
      mode_d.run = 1'b0;
    end
    load_req = wr_cur
             | (wr_ctrl & ((wmode[CTRL_RUN_BIT] & ~mode_q.run)
                         | (wmode[CTRL_SRC_BIT] ^ mode_q.src)));
    if (wrap)                  flag_d = 1'b1;
    else if (rd_ctrl | wr_cur) flag_d = 1'b0;
    else                       flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_ce) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reload_q <= '0;
    else if (wr_load) reload_q <= wreload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= wrap & mode_q.ie;
  end

  assign mode     = mode_q;
  assign flag     = flag_q;
  assign reload   = reload_q;
  assign tick_irq = irq_q;
endmodule

// File: rtl/stk_counter.sv
module stk_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src,
  input  logic             ref_tick_en,
  input  logic             load_req,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             step,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q, count_d;
  logic             count_ce;
  logic             at_zero;

  always_comb begin
    step     = run & (src | ref_tick_en);
    at_zero  = (count_q == '0);
    wrap     = step & ~load_req & at_zero;
    count_ce = load_req | step;
    count_d  = count_q;
    if (load_req)  count_d = reload;
    else if (step) count_d = at_zero ? reload : (count_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_ce) count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/stk_rdata_mux.sv
module stk_rdata_mux
  import stk_pkg::*;
#(
  parameter int          CNT_W     = 24,
  parameter logic [31:0] CAL_VALUE = 32'd10000
) (
  input  logic [1:0]       bus_addr,
  input  stk_mode_t        mode,
  input  logic             flag,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] reload,
  output logic [31:0]      rdata
);
  localparam int PAD_W = 32 - CNT_W;

  logic [31:0] ctrl_word;

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_RUN_BIT]  = mode.run;
    ctrl_word[CTRL_IE_BIT]   = mode.ie;
    ctrl_word[CTRL_SRC_BIT]  = mode.src;
    ctrl_word[CTRL_FLAG_BIT] = flag;
    case (bus_addr)
      REG_CTRL: rdata = ctrl_word;
      REG_LOAD: rdata = {{PAD_W{1'b0}}, reload};
      REG_CUR:  rdata = mode.run ? {{PAD_W{1'b0}}, count} : 32'd0;
      default:  rdata = CAL_VALUE;
    endcase
  end
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import stk_pkg::*;
#(
  parameter int          CNT_W     = 24,
  parameter logic [31:0] CAL_VALUE = 32'd10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick_en,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tick_irq
);
  logic             rst_sync_n;
  logic             wr_ctrl, wr_load, wr_cur, rd_ctrl;
  stk_mode_t        mode;
  logic             flag;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             load_req, step, wrap;
  logic             unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:CNT_W]};

  stk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  stk_bus_decode u_dec (
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wr_ctrl(wr_ctrl), .wr_load(wr_load), .wr_cur(wr_cur), .rd_ctrl(rd_ctrl)
  );

  stk_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_ctrl(wr_ctrl), .wr_load(wr_load), .wr_cur(wr_cur), .rd_ctrl(rd_ctrl),
    .wmode(bus_wdata[2:0]), .wreload(bus_wdata[CNT_W-1:0]), .wrap(wrap),
    .mode(mode), .flag(flag), .reload(reload), .load_req(load_req),
    .tick_irq(tick_irq)
  );

  stk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run(mode.run), .src(mode.src),
    .ref_tick_en(ref_tick_en), .load_req(load_req), .reload(reload),
    .count(count), .step(step), .wrap(wrap)
  );

  stk_rdata_mux #(.CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)) u_rmux (
    .bus_addr(bus_addr), .mode(mode), .flag(flag), .count(count),
    .reload(reload), .rdata(bus_rdata)
  );
endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             ie,
  input logic             flag,
  input logic             rd_ctrl,
  input logic             wr_ctrl,
  input logic             step,
  input logic             wrap,
  input logic             load_req,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             tick_irq
);
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_req) |=> $stable(count)); // R5

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_req && count != '0) |=> (count == $past(count) - CNT_W'(1))); // R4

  AST_BUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (count == $past(reload))); // R11

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag); // R6

  AST_FLAG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !wrap) |=> !flag); // R6

  AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ie) |=> tick_irq); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> flag || $past(rd_ctrl)); // R7

  AST_ZERO_RELOAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && reload == '0 && !wr_ctrl) |=> !run); // R9
endmodule

bind sys_tick_timer stk_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .run(mode.run), .ie(mode.ie), .flag(flag),
  .rd_ctrl(rd_ctrl), .wr_ctrl(wr_ctrl), .step(step), .wrap(wrap),
  .load_req(load_req), .count(count), .reload(reload), .tick_irq(tick_irq)
);

// File: tb/sys_tick_timer_tb.sv
module sys_tick_timer_tb;
  logic        clk;
  logic        rst_n;
  logic        ref_tick_en;
  logic        bus_rd;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int checks;
  int errors;
  bit done;

  sys_tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick_en(ref_tick_en), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_irq(tick_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // tasks start and end just after a negative edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int first_hit, second_hit, irq_seen;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; ref_tick_en = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_addr = 2'd0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, tick_irq}, 32'd0);
    rd_chk("R1 ctrl", 2'd0, 32'd0);
    rd_chk("R1 reload", 2'd1, 32'd0);
    rd_chk("R1 current", 2'd2, 32'd0);

    // R3 calibration constant, writes ignored
    rd_chk("R3 cal", 2'd3, 32'd10000);
    wr(2'd3, 32'd5);
    rd_chk("R3 cal after write", 2'd3, 32'd10000);

    // R2 only bits 2..0 writable
    wr(2'd0, 32'hFFFF_FFF8);
    rd_chk("R2 ctrl upper bits ignored", 2'd0, 32'd0);
    wr(2'd0, 32'hFFFF_0004);
    rd_chk("R2 ctrl src only", 2'd0, 32'd4);
    wr(2'd0, 32'd0);

    // R3 reload width, R10 current zero while stopped
    wr(2'd1, 32'hFFFF_FFFF);
    rd_chk("R3 reload width", 2'd1, 32'h00FF_FFFF);
    rd_chk("R10 current while stopped", 2'd2, 32'd0);

    // R4 R7 wrap period sweep, every-clock source
    for (int r = 1; r <= 13; r++) begin
      wr(2'd0, 32'd0);
      wr(2'd1, r);
      wr(2'd0, 32'd7);
      first_hit = -1; second_hit = -1;
      for (int k = 1; k <= 2 * r + 3; k++) begin
        @(negedge clk);
        if (tick_irq) begin
          if (first_hit < 0) first_hit = k;
          else if (second_hit < 0) second_hit = k;
        end
      end
      chk("R4 first wrap", first_hit, r + 1);
      chk("R7 second pulse", second_hit, 2 * r + 2);
    end
    wr(2'd0, 32'd0);
    rd(2'd0, v);

    // R6 sticky flag and read clear, R7 no request when disabled
    wr(2'd1, 32'd100);
    wr(2'd0, 32'd5);
    irq_seen = 0;
    for (int k = 1; k <= 101; k++) begin
      @(negedge clk);
      if (tick_irq) irq_seen++;
    end
    chk("R7 no request with ie=0", irq_seen, 0);
    rd_chk("R6 flag set", 2'd0, 32'h0001_0005);
    rd_chk("R6 flag cleared by read", 2'd0, 32'h0000_0005);

    // R8 write to current reloads
    wr(2'd1, 32'd50);
    wr(2'd0, 32'd0);
    wr(2'd0, 32'd5);
    repeat (10) @(negedge clk);
    wr(2'd2, 32'h123);
    rd_chk("R8 current reloaded", 2'd2, 32'd50);

    // R8 R11 clear flag, bus reload beats the pending wrap
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd2);
    wr(2'd0, 32'd5);
    repeat (5) @(negedge clk);
    wr(2'd2, 32'd0);
    rd_chk("R8 flag cleared by current write", 2'd0, 32'h0000_0005);

    // R9 zero reload one-shot
    wr(2'd0, 32'd0);
    rd(2'd0, v);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'd7);
    @(negedge clk);
    chk("R9 pulse", {31'd0, tick_irq}, 32'd1);
    rd_chk("R9 run cleared", 2'd0, 32'h0001_0006);
    rd_chk("R9 stays stopped", 2'd0, 32'h0000_0006);

    // R5 reference-tick gating
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd4);
    wr(2'd0, 32'd1);
    repeat (20) @(negedge clk);
    rd_chk("R5 no ref tick", 2'd2, 32'd4);
    ref_tick_en = 1'b1;
    repeat (3) @(negedge clk);
    ref_tick_en = 1'b0;
    rd_chk("R5 three ref ticks", 2'd2, 32'd1);

    // R11 source change reloads
    wr(2'd0, 32'd5);
    repeat (2) @(negedge clk);
    rd_chk("R5 every clock", 2'd2, 32'd2);
    wr(2'd0, 32'd1);
    rd_chk("R11 source change reload", 2'd2, 32'd4);

    // R10 stopped reads zero, R4 re-enable reloads
    wr(2'd0, 32'd0);
    rd_chk("R10 current zero", 2'd2, 32'd0);
    wr(2'd0, 32'd5);
    rd_chk("R4 re-enable reload", 2'd2, 32'd4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule